// File: doc/BRIEF.md
# Remap Shape Allocation Decoder

This block performs the configuration-write step of an instruction that sets up indexed element remapping. When `start` is pulsed it takes a 5-bit remap mask, a mask-mode bit and a set of shape parameters. The parameters are a dimension size code, a skip bit, a 2D-swap bit, an element-width code, an index register number and the maximum vector length. In a single clock edge it then rewrites four 32-bit shape registers and the remap control fields of a status area.

There are five operand slots: slots 0 to 2 are inputs and slots 3 and 4 are outputs. Each slot has a 2-bit selector that names the shape register applied to it. The status area also holds a 5-bit enable mask, with bit k belonging to slot k, and one persistence bit.

The mask-mode bit chooses how slots are bound to shapes:
- **Mode 0** clears everything. It then hands out shape numbers round-robin to the slots whose mask bit is set.
- **Mode 1** uses the mask as one explicit slot/shape pair.

Fetching index values and performing the remap are handled elsewhere.

Top module: `remap_shape_alloc`

## Requirements
- R1: After synchronous reset, all shape registers, selectors, the enable mask, the persistence bit, `done` and `illegal` are zero.
- R2: In mask mode 0, every shape register and every selector is first cleared. Set mask bits are then visited from slot 0 upward. Each visited slot's selector gets the next shape number, starting at 0, and that shape register is written with the instruction's shape word. Slots with a clear mask bit keep selector 0, and shapes not handed out stay zero.
- R3: In mask mode 0, the shape counter wraps modulo 4. With all five mask bits set, slot 4 gets shape 0.
- R4: In mask mode 0, the enable mask becomes equal to the remap mask and the persistence bit becomes 0.
- R5: In mask mode 1, the slot number is mask[4:2] and the shape number is mask[1:0]. Only that shape register and that slot's selector are written; all other shapes and selectors keep their values.
- R6: In a legal mask-mode-1 operation, the chosen slot's enable bit is set, the other enable bits are kept, and the persistence bit becomes 1.
- R7: In mask mode 1, a slot number of 5, 6 or 7 leaves all state unchanged. It pulses `illegal` for one cycle and does not pulse `done`.
- R8: A written shape word is packed as follows (all other bits are 0):

  | Bits | Content |
  |---|---|
  | [31:30] | mode, 00 |
  | [29:27] | permute: 110, or 111 when the 2D-swap bit is 1 |
  | [26:22] | dimension code, stored off-by-one (code c means size c+1) |
  | [21:15] | second-dimension code |
  | [14:8] | index register field shifted left by two |
  | [7:6] | element-width code |
  | [5] | skip bit |

- R9: When the 2D-swap bit is 1 and skip is 0, the second-dimension code is ceil(max_vl / (dim_code+1)) − 1, and 0 when max_vl is 0. In all other cases it is 0.
- R10: `done` is high for exactly the one cycle after a legal `start`. Without `start`, `done` and `illegal` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Execute the configuration write this cycle |
| mask_mode | input | 1 | 0 = round-robin allocation, 1 = explicit slot/shape pair |
| remap_mask | input | 5 | Slot mask (mode 0) or slot/shape selector (mode 1) |
| dim_code | input | 5 | First dimension size minus one |
| skip_dim | input | 1 | Skip bit copied into the shape word |
| swap_2d | input | 1 | Swap the two dimensions; enables derived second dimension |
| elem_width | input | 2 | Element-width code of the index values |
| index_reg | input | 5 | Index register field, scaled by four |
| max_vl | input | 7 | Maximum vector length |
| shape_regs | output | 128 | Shape register k at bits [32k+31:32k] |
| slot_sel | output | 10 | Selector of slot k at bits [2k+1:2k] |
| slot_en | output | 5 | Enable bit k for slot k |
| persist | output | 1 | Persistence bit |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-operand pulse |

## Verification
The bench uses the default package constants: five slots and four shapes, with 2-bit selectors and a 5-bit mask. At this size it can step through all 32 mask values in each mask mode against an arithmetic model of the allocation. That covers every round-robin wrap and every illegal slot code. It also sweeps every dimension code against every max_vl value, which exercises the ceiling division including the zero and full-length ends.

// File: rtl/remap_alloc_pkg.sv
package remap_alloc_pkg;
    localparam int NUM_SLOTS  = 5;
    localparam int NUM_SHAPES = 4;
    localparam int SEL_W      = $clog2(NUM_SHAPES);
    localparam int SLOT_W     = NUM_SLOTS - SEL_W;
    localparam int DIM_W      = 5;
    localparam int VL_W       = 7;
    localparam int IREG_W     = 5;
    localparam int REG_W      = IREG_W + 2;
    localparam int EW_W       = 2;
    localparam int WORD_W     = 32;
    localparam int PAD_W      = WORD_W - 2 - 3 - DIM_W - VL_W - REG_W - EW_W - 1;

    typedef struct packed {
        logic [1:0]        mode;
        logic [2:0]        permute;
        logic [DIM_W-1:0]  xdim;
        logic [VL_W-1:0]   ydim;
        logic [REG_W-1:0]  idx_reg;
        logic [EW_W-1:0]   elw;
        logic              skip;
        logic [PAD_W-1:0]  pad;
    } shape_word_t;

    localparam logic [2:0] PERM_XY = 3'b110;
    localparam logic [2:0] PERM_YX = 3'b111;

    // ceil(vl / (code+1)) - 1, floored at zero
    function automatic logic [VL_W-1:0] derive_ydim(
        input logic [VL_W-1:0] vl, input logic [DIM_W-1:0] code);
        logic [VL_W:0] num;
        logic [VL_W:0] den;
        logic [VL_W:0] q;
        num = {1'b0, vl} + (VL_W+1)'(code);
        den = (VL_W+1)'(code) + (VL_W+1)'(1);
        q   = num / den;
        if (q == '0) return '0;
        return VL_W'(q - (VL_W+1)'(1));
    endfunction
endpackage

// File: rtl/shape_word_gen.sv
module shape_word_gen
    import remap_alloc_pkg::*;
(
    input  logic [DIM_W-1:0]  dim_code,
    input  logic              skip_dim,
    input  logic              swap_2d,
    input  logic [EW_W-1:0]   elem_width,
    input  logic [IREG_W-1:0] index_reg,
    input  logic [VL_W-1:0]   max_vl,
    output shape_word_t       word
);
    always_comb begin
        word         = '0;
        word.mode    = 2'b00;
        word.permute = swap_2d ? PERM_YX : PERM_XY;
        word.xdim    = dim_code;
        word.ydim    = (swap_2d && !skip_dim) ? derive_ydim(max_vl, dim_code) : '0;
        word.idx_reg = {index_reg, 2'b00};
        word.elw     = elem_width;
        word.skip    = skip_dim;
    end
endmodule

// File: rtl/slot_allocator.sv
module slot_allocator
    import remap_alloc_pkg::*;
(
    input  logic                       mask_mode,
    input  logic [NUM_SLOTS-1:0]       remap_mask,
    input  logic [NUM_SLOTS*SEL_W-1:0] cur_sel,
    input  logic [NUM_SLOTS-1:0]       cur_en,
    output logic [NUM_SLOTS*SEL_W-1:0] nxt_sel,
    output logic [NUM_SLOTS-1:0]       nxt_en,
    output logic [NUM_SHAPES-1:0]      wr_shape,
    output logic                       clr_shapes,
    output logic                       nxt_persist,
    output logic                       bad_slot
);
    logic [SLOT_W-1:0] pick_slot;
    logic [SEL_W-1:0]  pick_shape;
    logic [SEL_W-1:0]  cnt;

    assign pick_slot  = remap_mask[NUM_SLOTS-1:SEL_W];
    assign pick_shape = remap_mask[SEL_W-1:0];
    assign bad_slot   = mask_mode && (32'(pick_slot) >= NUM_SLOTS);

    always_comb begin
        nxt_sel     = '0;
        nxt_en      = '0;
        wr_shape    = '0;
        clr_shapes  = 1'b0;
        nxt_persist = 1'b0;
        cnt         = '0;
        if (!mask_mode) begin
            clr_shapes = 1'b1;
            nxt_en     = remap_mask;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (remap_mask[s]) begin
                    nxt_sel[s*SEL_W +: SEL_W] = cnt;
                    wr_shape[cnt]             = 1'b1;
                    cnt                       = cnt + SEL_W'(1);
                end
            end
        end else begin
            nxt_sel     = cur_sel;
            nxt_en      = cur_en;
            nxt_persist = 1'b1;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (32'(pick_slot) == s) begin
                    nxt_sel[s*SEL_W +: SEL_W] = pick_shape;
                    nxt_en[s]                 = 1'b1;
                end
            end
            wr_shape[pick_shape] = !bad_slot;
        end
    end
endmodule

// File: rtl/remap_shape_alloc.sv
module remap_shape_alloc
    import remap_alloc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic                         mask_mode,
    input  logic [NUM_SLOTS-1:0]         remap_mask,
    input  logic [DIM_W-1:0]             dim_code,
    input  logic                         skip_dim,
    input  logic                         swap_2d,
    input  logic [EW_W-1:0]              elem_width,
    input  logic [IREG_W-1:0]            index_reg,
    input  logic [VL_W-1:0]              max_vl,
    output logic [NUM_SHAPES*WORD_W-1:0] shape_regs,
    output logic [NUM_SLOTS*SEL_W-1:0]   slot_sel,
    output logic [NUM_SLOTS-1:0]         slot_en,
    output logic                         persist,
    output logic                         done,
    output logic                         illegal
);
    shape_word_t                 new_word;
    logic [WORD_W-1:0]           shape_q [NUM_SHAPES];
    logic [NUM_SLOTS*SEL_W-1:0]  sel_q;
    logic [NUM_SLOTS-1:0]        en_q;
    logic                        pers_q;
    logic [NUM_SLOTS*SEL_W-1:0]  nxt_sel;
    logic [NUM_SLOTS-1:0]        nxt_en;
    logic [NUM_SHAPES-1:0]       wr_shape;
    logic                        clr_shapes;
    logic                        nxt_persist;
    logic                        bad_slot;

    shape_word_gen u_word (
        .dim_code   (dim_code),
        .skip_dim   (skip_dim),
        .swap_2d    (swap_2d),
        .elem_width (elem_width),
        .index_reg  (index_reg),
        .max_vl     (max_vl),
        .word       (new_word)
    );

    slot_allocator u_alloc (
        .mask_mode   (mask_mode),
        .remap_mask  (remap_mask),
        .cur_sel     (sel_q),
        .cur_en      (en_q),
        .nxt_sel     (nxt_sel),
        .nxt_en      (nxt_en),
        .wr_shape    (wr_shape),
        .clr_shapes  (clr_shapes),
        .nxt_persist (nxt_persist),
        .bad_slot    (bad_slot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_SHAPES; k++) shape_q[k] <= '0;
            sel_q   <= '0;
            en_q    <= '0;
            pers_q  <= 1'b0;
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            if (start) begin
                if (bad_slot) begin
                    illegal <= 1'b1;
                end else begin
                    done <= 1'b1;
                    for (int k = 0; k < NUM_SHAPES; k++) begin
                        if (wr_shape[k])     shape_q[k] <= new_word;
                        else if (clr_shapes) shape_q[k] <= '0;
                    end
                    sel_q  <= nxt_sel;
                    en_q   <= nxt_en;
                    pers_q <= nxt_persist;
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_SHAPES; g++) begin : g_out
            assign shape_regs[g*WORD_W +: WORD_W] = shape_q[g];
        end
    endgenerate

    assign slot_sel = sel_q;
    assign slot_en  = en_q;
    assign persist  = pers_q;

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        start && !(mask_mode && remap_mask[NUM_SLOTS-1:SEL_W] > SLOT_W'(NUM_SLOTS-1))
        |=> done && !illegal);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done && !illegal);
    assert_illegal_hold_R7: assert property (@(posedge clk) disable iff (rst)
        start && mask_mode && remap_mask[NUM_SLOTS-1:SEL_W] > SLOT_W'(NUM_SLOTS-1)
        |=> illegal && !done && $stable(shape_regs) && $stable(slot_sel)
            && $stable(slot_en) && $stable(persist));
    assert_mode0_enable_R4: assert property (@(posedge clk) disable iff (rst)
        start && !mask_mode |=> slot_en == $past(remap_mask) && !persist);
    assert_mode1_persist_R6: assert property (@(posedge clk) disable iff (rst)
        start && mask_mode && remap_mask[NUM_SLOTS-1:SEL_W] <= SLOT_W'(NUM_SLOTS-1)
        |=> persist && ($countones(slot_en) >= $countones($past(slot_en))));
endmodule

// File: tb/tb_remap_shape_alloc.sv
module tb_remap_shape_alloc;
    logic         clk = 1'b0;
    logic         rst;
    logic         start, mask_mode, skip_dim, swap_2d;
    logic [4:0]   remap_mask, dim_code, index_reg;
    logic [1:0]   elem_width;
    logic [6:0]   max_vl;
    logic [127:0] shape_regs;
    logic [9:0]   slot_sel;
    logic [4:0]   slot_en;
    logic         persist, done, illegal;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_shape [4];
    logic [1:0]  m_sel [5];
    logic [4:0]  m_en;
    logic        m_pers;

    always #10 clk = ~clk;

    remap_shape_alloc dut (
        .clk(clk), .rst(rst), .start(start), .mask_mode(mask_mode),
        .remap_mask(remap_mask), .dim_code(dim_code), .skip_dim(skip_dim),
        .swap_2d(swap_2d), .elem_width(elem_width), .index_reg(index_reg),
        .max_vl(max_vl), .shape_regs(shape_regs), .slot_sel(slot_sel),
        .slot_en(slot_en), .persist(persist), .done(done), .illegal(illegal)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(input int d, input int sk, input int sw,
                                            input int ew, input int ir, input int vl);
        int yd;
        yd = 0;
        if (sw == 1 && sk == 0 && vl > 0) yd = (vl + d) / (d + 1) - 1;
        return ((sw == 1 ? 32'd7 : 32'd6) << 27) | (32'(d) << 22) | (32'(yd) << 15)
             | (32'(ir * 4) << 8) | (32'(ew) << 6) | (32'(sk) << 5);
    endfunction

    task automatic check_state(input string tag);
        for (int k = 0; k < 4; k++) chk({tag, " shape"}, shape_regs[k*32 +: 32], m_shape[k]);
        for (int s = 0; s < 5; s++) chk({tag, " sel"}, 32'(slot_sel[s*2 +: 2]), 32'(m_sel[s]));
        chk({tag, " en"}, 32'(slot_en), 32'(m_en));
        chk({tag, " persist"}, 32'(persist), 32'(m_pers));
    endtask

    task automatic do_op(input int mm, input int mk, input int d, input int sk,
                         input int sw, input int ew, input int ir, input int vl,
                         input string tag, input bit full);
        logic [31:0] w;
        int cnt, slot, shp;
        bit bad;
        @(negedge clk);
        mask_mode = mm[0]; remap_mask = mk[4:0]; dim_code = d[4:0];
        skip_dim = sk[0]; swap_2d = sw[0]; elem_width = ew[1:0];
        index_reg = ir[4:0]; max_vl = vl[6:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = mk_word(d, sk, sw, ew, ir, vl);
        slot = mk >> 2; shp = mk & 3;
        bad = (mm == 1) && (slot > 4);
        chk("R10 done", 32'(done), bad ? 0 : 1);
        chk("R7 illegal", 32'(illegal), bad ? 1 : 0);
        if (mm == 0) begin
            for (int k = 0; k < 4; k++) m_shape[k] = '0;
            for (int s = 0; s < 5; s++) m_sel[s] = '0;
            cnt = 0;
            for (int s = 0; s < 5; s++)
                if (mk[s]) begin
                    m_sel[s] = 2'(cnt); m_shape[cnt] = w; cnt = (cnt + 1) % 4;
                end
            m_en = mk[4:0]; m_pers = 1'b0;
        end else if (!bad) begin
            m_shape[shp] = w; m_sel[slot] = 2'(shp);
            m_en[slot] = 1'b1; m_pers = 1'b1;
        end
        if (full) check_state(tag);
        else chk({tag, " shape"}, shape_regs[shp*32 +: 32], m_shape[shp]);
        @(negedge clk);
        if (full) begin
            chk("R10 done low", 32'(done), 0);
            chk("R10 illegal low", 32'(illegal), 0);
        end
    endtask

    initial begin
        #3000000;
        checks++; errors++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 0; mask_mode = 0; remap_mask = 0; dim_code = 0;
        skip_dim = 0; swap_2d = 0; elem_width = 0; index_reg = 0; max_vl = 0;
        for (int k = 0; k < 4; k++) m_shape[k] = '0;
        for (int s = 0; s < 5; s++) m_sel[s] = '0;
        m_en = '0; m_pers = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_state("R1 reset");
        chk("R1 done", 32'(done), 0);
        chk("R1 illegal", 32'(illegal), 0);

        // R2 R3 R4 R8 R9: every mask in round-robin mode
        for (int m = 0; m < 32; m++)
            do_op(0, m, m, (m % 3 == 0) ? 1 : 0, (m >> 1) & 1, m % 4, 31 - m,
                  m * 4 + 3, "R2 R3 R4 R8 R9", 1);

        // prepare a known state, then R5 R6 R7 over every selector
        do_op(0, 31, 3, 0, 0, 1, 9, 20, "R3 wrap", 1);
        for (int m = 0; m < 32; m++)
            do_op(1, m, 31 - m, m & 1, (m >> 2) & 1, (m >> 1) % 4, m,
                  127 - m, "R5 R6 R7", 1);

        // mode 0 after mode 1 clears persistence and old shapes
        do_op(0, 5'b00110, 7, 1, 1, 2, 17, 64, "R2 R4 clear", 1);

        // R9 sweep of the derived second dimension
        for (int d = 0; d < 32; d++)
            for (int vl = 0; vl < 128; vl++)
                do_op(1, 0, d, 0, 1, 0, 1, vl, "R9 ydim", 0);
        do_op(1, 0, 4, 1, 1, 0, 1, 100, "R9 skip", 1);
        do_op(1, 0, 4, 0, 0, 0, 1, 100, "R9 noswap", 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule